// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block keeps the two error counters of a CAN node, one for transmit errors and one for receive errors, and turns their values into the node's fault-confinement state. The state is one of three: error-active, error-passive or bus-off. The bit-stream sequencer raises and lowers the counters through per-counter command strobes. The block does not decide when a command is issued. It only applies the command, clamps the result and classifies the node.

While the node is bus-off, the counters are frozen. The block watches the sampled bus level on each bit-time strobe and counts runs of eleven consecutive recessive bits. After the 128th completed run, the node rejoins the bus as error-active with both counters cleared. A configuration input chooses whether the node rejoins in listen-only mode or in normal mode, and that choice is presented on a mode output. The state is also presented as a status flag word.

Top module: `canfc_top`

## Requirements
- R1: After a synchronous reset, both counters read 0, `state_o` reads 0 (error-active), `listen_only_o` reads 0 (normal mode) and `eflag_o` reads 8'h10.
- R2: An increment-by-1 or increment-by-8 command adds 1 or 8 to its counter on the next clock edge. If several commands for one counter arrive in the same cycle, increment-by-8 wins over increment-by-1, and increment-by-1 wins over decrement-by-1.
- R3: A decrement-by-1 command subtracts 1 from its counter. A decrement at zero leaves the counter at zero.
- R4: The receive counter saturates at 255. The transmit counter never exceeds 256, and an increment that would pass 256 yields exactly 256.
- R5: While both counters are below 128, `state_o` is 0 (error-active). While either counter is 128 or more and the node is not bus-off, `state_o` is 1 (error-passive). The state changes in the clock cycle after the counter change that causes it.
- R6: When the transmit counter reaches 256, `state_o` becomes 2 (bus-off) one cycle later and stays at 2 until recovery completes.
- R7: Counter commands that arrive while the transmit counter is 256 or the node is bus-off have no effect on either counter.
- R8: In bus-off, only bits sampled with `bit_stb` high count toward recovery. A recessive bit (`bus_bit`=1) extends the current run. A dominant bit restarts the current run of 11 but keeps the number of runs already completed. Recovery completes on the recessive bit that finishes the 128th run.
- R9: On the clock edge where recovery completes, both counters are cleared to 0, and `state_o` becomes 0 on that same edge.
- R10: On recovery, `listen_only_o` takes the value of `rejoin_listen`. It holds that value at all other times until the next recovery or reset.
- R11: `eflag_o` contains these bits, and all others are 0:
  - bit 0: receive counter is 128 or more.
  - bit 1: transmit counter is 128 or more.
  - bit 2: bus-off.
  - bit 3: error-passive.
  - bit 4: error-active.
  - bit 5: listen-only mode.

  Exactly one of bits 2 to 4 is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe marking a sampled bus bit |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| tec_inc1 | input | 1 | Add 1 to the transmit counter |
| tec_inc8 | input | 1 | Add 8 to the transmit counter |
| tec_dec1 | input | 1 | Subtract 1 from the transmit counter |
| rec_inc1 | input | 1 | Add 1 to the receive counter |
| rec_inc8 | input | 1 | Add 8 to the receive counter |
| rec_dec1 | input | 1 | Subtract 1 from the receive counter |
| rejoin_listen | input | 1 | Rejoin in listen-only mode after bus-off when 1 |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | 0 error-active, 1 error-passive, 2 bus-off |
| eflag_o | output | 8 | Error-flag status word |
| listen_only_o | output | 1 | 1 when the node runs in listen-only mode |

## Verification
The assertions check the following on every cycle:
- the state classification one cycle after each counter value;
- entry into bus-off once the transmit counter reaches 256;
- the freeze of both counters during bus-off;
- the decrement floor and the transmit ceiling;
- cleared counters at exit from bus-off;
- the stability of the mode output outside recovery;
- the one-hot state bits of the flag word.

Some behaviour only the bench scenarios can show. One is the exact length of the recovery sequence: recovery must not finish one bit early. Another is that a dominant bit restarts only the current run. A third is that bits without a strobe are ignored. The bench also checks the command priority, the saturation values and the mode chosen at rejoin.

// File: rtl/canfc_pkg.sv
package canfc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;

  localparam int EF_RXP    = 0;
  localparam int EF_TXP    = 1;
  localparam int EF_BOFF   = 2;
  localparam int EF_PASS   = 3;
  localparam int EF_ACT    = 4;
  localparam int EF_LISTEN = 5;
  localparam int EF_W      = 8;

endpackage

// File: rtl/canfc_sat_ctr.sv
module canfc_sat_ctr #(
  parameter int W    = 8,
  parameter int MAXV = 255,
  parameter int STEP = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         freeze,
  input  logic         inc1,
  input  logic         incb,
  input  logic         dec1,
  output logic [W-1:0] cnt
);

  localparam logic [W:0] MAXW  = (W+1)'(MAXV);
  localparam logic [W:0] STEPW = (W+1)'(STEP);
  localparam logic [W:0] ONEW  = (W+1)'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W:0]   sum_big;
  logic [W:0]   sum_one;

  always_comb begin
    sum_big = {1'b0, cnt_q} + STEPW;
    sum_one = {1'b0, cnt_q} + ONEW;
    cnt_d   = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (!freeze) begin
      if (incb) begin
        cnt_d = (sum_big > MAXW) ? MAXW[W-1:0] : sum_big[W-1:0];
      end else if (inc1) begin
        cnt_d = (sum_one > MAXW) ? MAXW[W-1:0] : sum_one[W-1:0];
      end else if (dec1 && (cnt_q != '0)) begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/canfc_recovery.sv
module canfc_recovery #(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic bit_stb,
  input  logic bus_bit,
  output logic done
);

  localparam int BW = (RUN_LEN   > 1) ? $clog2(RUN_LEN)   : 1;
  localparam int RW = (RUN_COUNT > 1) ? $clog2(RUN_COUNT) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(RUN_LEN - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_COUNT - 1);

  logic [BW-1:0] bit_q;
  logic [RW-1:0] run_q;
  logic          run_end;

  assign run_end = active && bit_stb && bus_bit && (bit_q == BIT_LAST);
  assign done    = run_end && (run_q == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      bit_q <= '0;
      run_q <= '0;
    end else if (bit_stb) begin
      if (!bus_bit) begin
        bit_q <= '0;
      end else if (run_end) begin
        bit_q <= '0;
        run_q <= done ? '0 : run_q + RW'(1);
      end else begin
        bit_q <= bit_q + BW'(1);
      end
    end
  end

endmodule

// File: rtl/canfc_state.sv
module canfc_state
  import canfc_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TEC_W-1:0] tec,
  input  logic [REC_W-1:0] rec,
  input  logic             recov_done,
  input  logic             rejoin_listen,
  output fc_state_e        state_q,
  output logic [EF_W-1:0]  eflag_q,
  output logic             listen_q
);

  localparam logic [TEC_W-1:0] TEC_PLIM = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_BLIM = TEC_W'(BUSOFF_LIM);
  localparam logic [REC_W-1:0] REC_PLIM = REC_W'(PASSIVE_LIM);

  fc_state_e       state_d;
  logic            listen_d;
  logic [EF_W-1:0] eflag_d;
  logic            rx_hi;
  logic            tx_hi;

  assign rx_hi = (rec >= REC_PLIM);
  assign tx_hi = (tec >= TEC_PLIM);

  always_comb begin
    state_d  = state_q;
    listen_d = listen_q;
    if (state_q == FC_BUSOFF) begin
      if (recov_done) begin
        state_d  = FC_ACTIVE;
        listen_d = rejoin_listen;
      end
    end else if (tec >= TEC_BLIM) begin
      state_d = FC_BUSOFF;
    end else if (rx_hi || tx_hi) begin
      state_d = FC_PASSIVE;
    end else begin
      state_d = FC_ACTIVE;
    end
  end

  always_comb begin
    eflag_d            = '0;
    eflag_d[EF_RXP]    = rx_hi && !recov_done;
    eflag_d[EF_TXP]    = tx_hi && !recov_done;
    eflag_d[EF_BOFF]   = (state_d == FC_BUSOFF);
    eflag_d[EF_PASS]   = (state_d == FC_PASSIVE);
    eflag_d[EF_ACT]    = (state_d == FC_ACTIVE);
    eflag_d[EF_LISTEN] = listen_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= FC_ACTIVE;
      listen_q <= 1'b0;
      eflag_q  <= EF_W'(1 << EF_ACT);
    end else begin
      state_q  <= state_d;
      listen_q <= listen_d;
      eflag_q  <= eflag_d;
    end
  end

endmodule

// File: rtl/canfc_top.sv
module canfc_top
  import canfc_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256,
  parameter int BIG_STEP    = 8,
  parameter int RUN_LEN     = 11,
  parameter int RUN_COUNT   = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             bus_bit,
  input  logic             tec_inc1,
  input  logic             tec_inc8,
  input  logic             tec_dec1,
  input  logic             rec_inc1,
  input  logic             rec_inc8,
  input  logic             rec_dec1,
  input  logic             rejoin_listen,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic [EF_W-1:0]  eflag_o,
  output logic             listen_only_o
);

  localparam int REC_MAX = (1 << REC_W) - 1;
  localparam logic [TEC_W-1:0] TEC_BLIM = TEC_W'(BUSOFF_LIM);

  fc_state_e        state_q;
  logic [TEC_W-1:0] tec_q;
  logic [REC_W-1:0] rec_q;
  logic             busoff;
  logic             freeze;
  logic             recov_done;

  assign busoff = (state_q == FC_BUSOFF);
  assign freeze = busoff || (tec_q >= TEC_BLIM);

  canfc_sat_ctr #(.W(TEC_W), .MAXV(BUSOFF_LIM), .STEP(BIG_STEP)) u_tec (
    .clk(clk), .rst(rst), .clr(recov_done), .freeze(freeze),
    .inc1(tec_inc1), .incb(tec_inc8), .dec1(tec_dec1), .cnt(tec_q)
  );

  canfc_sat_ctr #(.W(REC_W), .MAXV(REC_MAX), .STEP(BIG_STEP)) u_rec (
    .clk(clk), .rst(rst), .clr(recov_done), .freeze(freeze),
    .inc1(rec_inc1), .incb(rec_inc8), .dec1(rec_dec1), .cnt(rec_q)
  );

  canfc_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
    .clk(clk), .rst(rst), .active(busoff), .bit_stb(bit_stb),
    .bus_bit(bus_bit), .done(recov_done)
  );

  canfc_state #(
    .TEC_W(TEC_W), .REC_W(REC_W),
    .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
  ) u_state (
    .clk(clk), .rst(rst), .tec(tec_q), .rec(rec_q),
    .recov_done(recov_done), .rejoin_listen(rejoin_listen),
    .state_q(state_q), .eflag_q(eflag_o), .listen_q(listen_only_o)
  );

  assign tec_o   = tec_q;
  assign rec_o   = rec_q;
  assign state_o = state_q;

endmodule

// File: rtl/canfc_chk.sv
module canfc_chk #(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             tec_inc1,
  input logic             tec_inc8,
  input logic             tec_dec1,
  input logic             rec_inc1,
  input logic             rec_inc8,
  input logic             rec_dec1,
  input logic [TEC_W-1:0] tec_o,
  input logic [REC_W-1:0] rec_o,
  input logic [1:0]       state_o,
  input logic [7:0]       eflag_o,
  input logic             listen_only_o
);

  localparam logic [1:0] S_ACT  = 2'd0;
  localparam logic [1:0] S_PASS = 2'd1;
  localparam logic [1:0] S_BOFF = 2'd2;
  localparam logic [TEC_W-1:0] TP = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TB = TEC_W'(BUSOFF_LIM);
  localparam logic [REC_W-1:0] RP = REC_W'(PASSIVE_LIM);

  assert_active_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o != S_BOFF && tec_o < TP && rec_o < RP) |=> state_o == S_ACT);

  assert_passive_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o != S_BOFF && tec_o < TB && (tec_o >= TP || rec_o >= RP)) |=> state_o == S_PASS);

  assert_enter_busoff_R6: assert property (@(posedge clk) disable iff (rst)
    (state_o != S_BOFF && tec_o >= TB) |=> state_o == S_BOFF);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_BOFF) |=> (state_o != S_BOFF || ($stable(tec_o) && $stable(rec_o))));

  assert_dec_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (rec_o == '0 && rec_dec1 && !rec_inc1 && !rec_inc8) |=> rec_o == '0);

  assert_tec_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (tec_o == '0 && tec_dec1 && !tec_inc1 && !tec_inc8) |=> tec_o == '0);

  assert_tec_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
    tec_o <= TB);

  assert_cleared_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_BOFF) |=> (state_o == S_BOFF || (tec_o == '0 && rec_o == '0)));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (state_o != S_BOFF) |=> $stable(listen_only_o));

  assert_flag_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $countones(eflag_o[4:2]) == 1);

endmodule

bind canfc_top canfc_chk #(
  .TEC_W(TEC_W), .REC_W(REC_W),
  .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
) u_chk (
  .clk(clk), .rst(rst),
  .tec_inc1(tec_inc1), .tec_inc8(tec_inc8), .tec_dec1(tec_dec1),
  .rec_inc1(rec_inc1), .rec_inc8(rec_inc8), .rec_dec1(rec_dec1),
  .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o),
  .eflag_o(eflag_o), .listen_only_o(listen_only_o)
);

// File: tb/canfc_top_tb.sv
`timescale 1ns/1ps
module canfc_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_stb = 1'b0;
  logic       bus_bit = 1'b1;
  logic       tec_inc1 = 1'b0, tec_inc8 = 1'b0, tec_dec1 = 1'b0;
  logic       rec_inc1 = 1'b0, rec_inc8 = 1'b0, rec_dec1 = 1'b0;
  logic       rejoin_listen = 1'b0;
  logic [8:0] tec_o;
  logic [7:0] rec_o;
  logic [1:0] state_o;
  logic [7:0] eflag_o;
  logic       listen_only_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  canfc_top u_dut (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bus_bit(bus_bit),
    .tec_inc1(tec_inc1), .tec_inc8(tec_inc8), .tec_dec1(tec_dec1),
    .rec_inc1(rec_inc1), .rec_inc8(rec_inc8), .rec_dec1(rec_dec1),
    .rejoin_listen(rejoin_listen),
    .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o),
    .eflag_o(eflag_o), .listen_only_o(listen_only_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  // order: tec_inc1, tec_inc8, tec_dec1, rec_inc1, rec_inc8, rec_dec1
  task automatic cmd(input logic [5:0] v);
    @(negedge clk);
    {tec_inc1, tec_inc8, tec_dec1, rec_inc1, rec_inc8, rec_dec1} = v;
    @(negedge clk);
    {tec_inc1, tec_inc8, tec_dec1, rec_inc1, rec_inc8, rec_dec1} = '0;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_stb = 1'b1; bus_bit = b;
    @(negedge clk); bit_stb = 1'b0; bus_bit = 1'b1;
  endtask

  task automatic send_runs(input int n);
    for (int r = 0; r < n; r++)
      for (int k = 0; k < 11; k++) send_bit(1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tec", tec_o, 0);
    chk("R1 rec", rec_o, 0);
    chk("R1 state", state_o, 0);
    chk("R1 listen", listen_only_o, 0);
    chk("R1 eflag", eflag_o, 8'h10);
  endtask

  task automatic t_incr();
    do_reset();
    cmd(6'b100000); chk("R2 tec+1", tec_o, 1);
    cmd(6'b010000); chk("R2 tec+8", tec_o, 9);
    cmd(6'b111000); chk("R2 tec priority inc8", tec_o, 17);
    cmd(6'b000100); chk("R2 rec+1", rec_o, 1);
    cmd(6'b000010); chk("R2 rec+8", rec_o, 9);
    cmd(6'b000101); chk("R2 rec priority inc1 over dec1", rec_o, 10);
    cmd(6'b001000); chk("R3 tec-1", tec_o, 16);
    chk("R5 still active", state_o, 0);
  endtask

  task automatic t_dec_floor();
    do_reset();
    cmd(6'b000001); chk("R3 rec floor", rec_o, 0);
    cmd(6'b001000); chk("R3 tec floor", tec_o, 0);
    cmd(6'b100100); cmd(6'b001001);
    chk("R3 tec 1->0", tec_o, 0);
    chk("R3 rec 1->0", rec_o, 0);
  endtask

  task automatic t_passive();
    do_reset();
    for (int i = 0; i < 15; i++) cmd(6'b000010);
    chk("R5 rec 120 active", state_o, 0);
    @(negedge clk);
    rec_inc8 = 1'b1;
    @(negedge clk);
    rec_inc8 = 1'b0;
    chk("R5 rec at 128", rec_o, 128);
    chk("R5 state lags counter", state_o, 0);
    @(negedge clk);
    chk("R5 passive", state_o, 1);
    chk("R11 eflag passive rx", eflag_o, 8'h09);
    for (int i = 0; i < 20; i++) cmd(6'b000010);
    chk("R4 rec saturates", rec_o, 255);
    cmd(6'b000100); chk("R4 rec inc1 at max", rec_o, 255);
    cmd(6'b000001); chk("R3 rec 254", rec_o, 254);
  endtask

  task automatic to_busoff();
    for (int i = 0; i < 31; i++) cmd(6'b010000);
    for (int i = 0; i < 4; i++) cmd(6'b100000);
    chk("R5 tec 252 passive", state_o, 1);
    cmd(6'b010000);
    chk("R4 tec clamps at 256", tec_o, 256);
    chk("R6 bus-off", state_o, 2);
  endtask

  task automatic t_busoff();
    to_busoff();
    chk("R11 eflag bus-off", eflag_o, 8'h07);
    cmd(6'b001001);
    chk("R7 tec frozen", tec_o, 256);
    chk("R7 rec frozen", rec_o, 254);
    cmd(6'b000100);
    chk("R7 rec inc ignored", rec_o, 254);
  endtask

  task automatic t_recovery(input logic lo);
    rejoin_listen = lo;
    bus_bit = 1'b1;
    for (int i = 0; i < 30; i++) @(negedge clk);
    chk("R8 no strobe no progress", state_o, 2);
    send_runs(127);
    for (int k = 0; k < 10; k++) send_bit(1'b1);
    send_bit(1'b0);
    for (int k = 0; k < 10; k++) send_bit(1'b1);
    chk("R8 dominant restarts run", state_o, 2);
    send_bit(1'b1);
    @(negedge clk);
    chk("R9 state active", state_o, 0);
    chk("R9 tec cleared", tec_o, 0);
    chk("R9 rec cleared", rec_o, 0);
    chk("R10 mode", listen_only_o, lo);
    chk("R11 eflag after recovery", eflag_o, lo ? 8'h30 : 8'h10);
  endtask

  initial begin
    t_reset();
    t_incr();
    t_dec_floor();
    t_passive();
    t_busoff();
    t_recovery(1'b1);
    rejoin_listen = 1'b0;
    cmd(6'b100000);
    chk("R10 mode holds", listen_only_o, 1);
    to_busoff();
    t_recovery(1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule